// File: doc/BRIEF.md
# Press-and-Hold Step Generator

This block turns one button's debounced level, together with the strobe that marks a qualified press, into single-cycle step requests for an up/down position counter. A short press yields exactly one step. If the button is kept down, the block waits through a long start delay. It then issues a second step and moves into a repeating mode, where it issues one step per repeat period until the button is let go.

All timing counts a slow timebase tick, nominally one per millisecond, that the surrounding logic supplies. The start delay and the repeat period are parameters, because the oscillator behind the tick may drift by roughly a third either way. The defaults are 800 ticks and 250 ticks, which give four steps per second once repeating. One instance serves one direction. The position counter, its end-stop saturation and the debouncing of the raw contact are all outside this block.

Top module: `hold_step_detector`

## Requirements
- R1: After reset `stepPulse` is low, and it stays low until a press strobe is seen.
- R2: A `pressStrobe` sampled while the block is idle makes `stepPulse` high for exactly the next clock cycle. Idle means no press is in progress.
- R3: If `btnLevel` falls before START_TICKS ticks have been sampled after the strobe cycle, no step follows the first one.
- R4: If `btnLevel` stays high while START_TICKS ticks are sampled after the strobe cycle, one step is issued in the cycle after the edge that samples the START_TICKS-th tick, and repeat mode begins.
- R5: In repeat mode, one step is issued after every REPEAT_TICKS further ticks sampled with `btnLevel` high.
- R6: A low `btnLevel` ends a press at once and wins over a tick sampled on the same edge, so that tick issues no step. The next press starts its timing from zero.
- R7: A `pressStrobe` sampled while a press is in progress has no effect on `stepPulse` or on the timing.
- R8: Ticks sampled while idle cause no step and do not advance the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle timebase tick |
| btnLevel | input | 1 | Debounced button level, 1 = held |
| pressStrobe | input | 1 | One-cycle qualified-press strobe |
| stepPulse | output | 1 | One-cycle step request |

## Verification
Most faults in the tick counter or the mode register show up as a step pulse that is early, late, extra or missing. A tick count that is off by one moves the second step by one tick period, which is a few clocks. A mode that is not cleared on release shows up on the next press, when the second step lands too soon. Because the bench compares `stepPulse` against its model on every clock, such a fault is reported in the first cycle where the pulse differs. The totals per scenario then confirm the number of steps.

// File: rtl/hold_step_pkg.sv
package hold_step_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_HELD_WAIT = 2'd1,
    ST_AUTOSCAN  = 2'd2
  } holdState_t;

  // control -> datapath
  typedef struct packed {
    logic clear;
    logic advance;
  } cntCmd_t;

  // datapath -> control
  typedef struct packed {
    logic startHit;
    logic repeatHit;
  } cntSts_t;

endpackage

// File: rtl/hold_tick_counter.sv
module hold_tick_counter
  import hold_step_pkg::*;
#(
  parameter int START_TICKS  = 800,
  parameter int REPEAT_TICKS = 250,
  parameter int CNT_W        = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  output cntSts_t          sts,
  output logic [CNT_W-1:0] tickCnt
);

  localparam logic [CNT_W-1:0] START_LAST  = CNT_W'(START_TICKS - 1);
  localparam logic [CNT_W-1:0] REPEAT_LAST = CNT_W'(REPEAT_TICKS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (cmd.clear) begin
      tickCnt <= '0;
    end else if (cmd.advance) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    sts.startHit  = (tickCnt == START_LAST);
    sts.repeatHit = (tickCnt == REPEAT_LAST);
  end

endmodule

// File: rtl/hold_step_ctrl.sv
module hold_step_ctrl
  import hold_step_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       btnLevel,
  input  logic       pressStrobe,
  input  cntSts_t    sts,
  output cntCmd_t    cmd,
  output holdState_t state,
  output logic       stepPulse
);

  holdState_t stateNext;
  logic       stepNext;

  always_comb begin
    stateNext   = state;
    stepNext    = 1'b0;
    cmd.clear   = 1'b0;
    cmd.advance = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pressStrobe) begin
          stateNext = ST_HELD_WAIT;
          stepNext  = 1'b1;
          cmd.clear = 1'b1;
        end
      end
      ST_HELD_WAIT: begin
        if (!btnLevel) begin
          stateNext = ST_IDLE;
          cmd.clear = 1'b1;
        end else if (msTick) begin
          if (sts.startHit) begin
            stateNext = ST_AUTOSCAN;
            stepNext  = 1'b1;
            cmd.clear = 1'b1;
          end else begin
            cmd.advance = 1'b1;
          end
        end
      end
      ST_AUTOSCAN: begin
        if (!btnLevel) begin
          stateNext = ST_IDLE;
          cmd.clear = 1'b1;
        end else if (msTick) begin
          if (sts.repeatHit) begin
            stepNext  = 1'b1;
            cmd.clear = 1'b1;
          end else begin
            cmd.advance = 1'b1;
          end
        end
      end
      default: begin
        stateNext = ST_IDLE;
        cmd.clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepPulse <= 1'b0;
    end else begin
      state     <= stateNext;
      stepPulse <= stepNext;
    end
  end

endmodule

// File: rtl/hold_step_detector.sv
module hold_step_detector
  import hold_step_pkg::*;
#(
  parameter int START_TICKS  = 800,
  parameter int REPEAT_TICKS = 250
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic btnLevel,
  input  logic pressStrobe,
  output logic stepPulse
);

  localparam int MAX_TICKS = (START_TICKS > REPEAT_TICKS) ? START_TICKS : REPEAT_TICKS;
  localparam int CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;

  cntCmd_t          cntCmd;
  cntSts_t          cntSts;
  holdState_t       ctrlState;
  logic [CNT_W-1:0] tickCnt;

  hold_step_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .msTick     (msTick),
    .btnLevel   (btnLevel),
    .pressStrobe(pressStrobe),
    .sts        (cntSts),
    .cmd        (cntCmd),
    .state      (ctrlState),
    .stepPulse  (stepPulse)
  );

  hold_tick_counter #(
    .START_TICKS (START_TICKS),
    .REPEAT_TICKS(REPEAT_TICKS),
    .CNT_W       (CNT_W)
  ) cnt_i (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cntCmd),
    .sts    (cntSts),
    .tickCnt(tickCnt)
  );

endmodule

// File: rtl/hold_step_checker.sv
module hold_step_checker
  import hold_step_pkg::*;
#(
  parameter int START_TICKS  = 800,
  parameter int REPEAT_TICKS = 250,
  parameter int CNT_W        = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             msTick,
  input logic             btnLevel,
  input logic             pressStrobe,
  input logic             stepPulse,
  input holdState_t       state,
  input logic [CNT_W-1:0] tickCnt
);

  a_r2_idle_press_steps: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && pressStrobe) |=> stepPulse);

  a_r8_idle_no_step: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !pressStrobe) |=> !stepPulse);

  a_r6_release_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!btnLevel && !pressStrobe) |=> !stepPulse);

  a_r7_busy_strobe_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && btnLevel && !msTick) |=> !stepPulse);

  a_r4_wait_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HELD_WAIT) |-> (int'(tickCnt) < START_TICKS));

  a_r5_repeat_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_AUTOSCAN) |-> (int'(tickCnt) < REPEAT_TICKS));

endmodule

bind hold_step_detector hold_step_checker #(
  .START_TICKS (START_TICKS),
  .REPEAT_TICKS(REPEAT_TICKS),
  .CNT_W       (CNT_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .msTick     (msTick),
  .btnLevel   (btnLevel),
  .pressStrobe(pressStrobe),
  .stepPulse  (stepPulse),
  .state      (ctrlState),
  .tickCnt    (tickCnt)
);

// File: tb/hold_step_detector_tb_top.sv
module hold_step_detector_tb_top;

  localparam int START_T  = 8;
  localparam int REPEAT_T = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic btnLevel = 1'b0;
  logic pressStrobe = 1'b0;
  logic stepPulse;

  int total = 0;
  int bad = 0;
  int stepSeen = 0;
  bit finished = 0;

  // reference model state
  bit     mHeld = 0;
  integer mTicks = 0;
  bit     expStep = 0;

  always #4 clk = ~clk;

  hold_step_detector #(.START_TICKS(START_T), .REPEAT_TICKS(REPEAT_T)) dut_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .btnLevel(btnLevel),
    .pressStrobe(pressStrobe), .stepPulse(stepPulse)
  );

  // behavioural model: ticks held since press decide the step instants
  always @(posedge clk) begin
    if (!rstN) begin
      mHeld = 0; mTicks = 0; expStep = 0;
    end else begin
      expStep = 0;
      if (!mHeld) begin
        if (pressStrobe) begin
          expStep = 1; mHeld = 1; mTicks = 0;
        end
      end else if (!btnLevel) begin
        mHeld = 0;
      end else if (msTick) begin
        mTicks = mTicks + 1;
        if (mTicks == START_T) expStep = 1;
        else if (mTicks > START_T && ((mTicks - START_T) % REPEAT_T) == 0) expStep = 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      total++;
      if (stepPulse !== expStep) begin
        bad++;
        $display("FAIL R2/R4/R5 per-cycle stepPulse actual=%0d expected=%0d at %0t",
                 stepPulse, expStep, $time);
      end
      if (stepPulse === 1'b1) stepSeen++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    idle(3);
    @(negedge clk) msTick = 1'b1;
    @(negedge clk) msTick = 1'b0;
  endtask

  task automatic press();
    @(negedge clk); btnLevel = 1'b1; pressStrobe = 1'b1;
    @(negedge clk); pressStrobe = 1'b0;
  endtask

  task automatic release_btn();
    btnLevel = 1'b0;
    idle(6);
  endtask

  task automatic expectSteps(input string tag, input int exp);
    check(stepSeen == exp, tag, stepSeen, exp);
    stepSeen = 0;
  endtask

  task automatic holdFor(input int n);
    press();
    for (int i = 0; i < n; i++) tick();
    release_btn();
  endtask

  initial begin
    idle(4);
    check(stepPulse == 1'b0, "R1 reset output", stepPulse, 0);
    @(negedge clk) rstN = 1'b1;
    idle(5);
    expectSteps("R1 no step before press", 0);

    // R8: ticks while idle
    for (int i = 0; i < 10; i++) tick();
    expectSteps("R8 idle ticks", 0);

    // R2/R3: short presses
    holdFor(0);
    expectSteps("R2 single step quick release", 1);
    holdFor(5);
    expectSteps("R3 short hold", 1);
    holdFor(START_T - 1);
    expectSteps("R3 hold one tick short", 1);

    // R4: exactly start delay
    holdFor(START_T);
    expectSteps("R4 start step", 2);

    // R5: repeat mode
    holdFor(START_T + REPEAT_T - 1);
    expectSteps("R5 before first repeat", 2);
    holdFor(START_T + 4 * REPEAT_T);
    expectSteps("R5 four repeats", 6);

    // R6: release on the same edge as a tick
    press();
    for (int i = 0; i < START_T + REPEAT_T - 1; i++) tick();
    idle(3);
    @(negedge clk); msTick = 1'b1; btnLevel = 1'b0;
    @(negedge clk); msTick = 1'b0;
    idle(6);
    expectSteps("R6 release beats tick", 2);
    holdFor(START_T);
    expectSteps("R6 fresh timing after release", 2);

    // R7: extra strobes while held
    press();
    for (int i = 0; i < 5; i++) begin
      idle(1);
      @(negedge clk) pressStrobe = 1'b1;
      @(negedge clk) pressStrobe = 1'b0;
      tick();
    end
    release_btn();
    expectSteps("R7 strobe while waiting", 1);

    press();
    for (int i = 0; i < START_T + 1; i++) tick();
    @(negedge clk) pressStrobe = 1'b1;
    @(negedge clk) pressStrobe = 1'b0;
    for (int i = 0; i < 2; i++) tick();
    release_btn();
    expectSteps("R7 strobe in repeat mode", 3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule